// File: doc/BRIEF.md
# Multi-Word Program and Verify Sequencer

This block is the bus-side controller for the multiple-word program command of a flash-style memory. After the command has been entered (the `cmd_start` pulse), the host streams words into the block. The first write of a phase carries a full start address. Every later write only has to repeat the upper address bits (21..17) of that start address, and the block steps its own internal word pointer. A write whose upper bits differ from the start address is the closing write of the phase. The program pass is followed by a verify pass: the host resends the same words in the same order, and each one is compared with the stored word. A clean verify returns the block to read mode. Any mismatch latches an error that only the reset command clears.

Storage is modelled as a 64-word array of 16-bit registers. The array starts fully erased, and a program write can only clear bits. Bus reads go through `rd_en`/`rd_addr`, and the result appears on `rd_data` one cycle later. In read mode the read returns array data. At all other times it returns a status word:
- bit 7: ready.
- bit 6: toggles on each status read.
- bit 5: error.
- bit 4: supply fault.
- all other bits: 0.

The write stream uses a valid/ready handshake. `wr_ready` is low in read mode, in the error state, and for `PROG_CYC` cycles after each accepted write. A write is taken only on a clock edge where both `wr_valid` and `wr_ready` are high. The host may hold `wr_valid` high while `wr_ready` is low, and nothing is consumed.

Top module: `mwp_seq`

## Requirements
- R1: After reset the block is in read mode with `wr_ready` low, and every array word reads as 16'hFFFF.
- R2: The first accepted write of a phase stores its data at word index `wr_addr[5:0]` and latches `wr_addr[21:17]` as the phase tag. Each later write with the same tag stores at the next index. Bits 16..0 of that later write are ignored.
- R3: A write whose bits 21..17 differ from the phase tag (bit 17 alone suffices) closes the phase and stores nothing. A closing program write moves the block into the verify pass.
- R4: A program write stores old AND new, so a bit at 0 never returns to 1.
- R5: In the verify pass each resent word is compared with the word at the stepped index. A closing write with no mismatch returns the block to read mode, and reads return array data again.
- R6: A verify mismatch enters the error state. In that state `wr_ready` is 0, writes are not taken, and a status read (once the write gap has passed) shows bit 7=1, bit 5=1 with bit 6 still toggling.
- R7: Status bit 4 is set in the error state if `supply_fail` was high on the mismatching write, and is 0 otherwise.
- R8: Outside read mode, `cmd_start` is ignored, and so is `cmd_reset` except in the error state. Every read returns the status word, with bits 15..8 and 3..0 equal to 0.
- R9: `cmd_reset` in the error state returns the block to read mode with the array contents kept.
- R10: After each accepted write, `wr_ready` and status bit 7 stay 0 for `PROG_CYC` cycles.
- R11: Status bit 6 inverts between any two successive status reads.
- R12: The word index wraps from 63 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Enters the multi-word program command (accepted in read mode) |
| cmd_reset | input | 1 | Read/reset command (effective in the error state) |
| supply_fail | input | 1 | Programming supply fault indication |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Block can take a write this cycle |
| wr_addr | input | 22 | Write address (bits 21..17 tag, bits 5..0 start index) |
| wr_data | input | 16 | Write data word |
| rd_en | input | 1 | Bus read request |
| rd_addr | input | 6 | Array index for reads in read mode |
| rd_data | output | 16 | Read result, valid the cycle after `rd_en` |

## Verification
A pointer that fails to step or wrap would store words at the wrong indexes. This only shows at the ports after the verify pass returns to read mode, when readback of the wrapped range returns the wrong values. A wrong phase decode shows sooner. A closing write taken as data leaves a cleared word one past the burst, and a verify that never ends leaves reads returning status instead of data. A lost error latch shows on the very next status read, as bit 5 or bit 4 missing, or as a `wr_ready` that rises again.

// File: rtl/mwp_pkg.sv
package mwp_pkg;
  typedef enum logic [2:0] {
    ST_READ   = 3'd0,
    ST_PFIRST = 3'd1,
    ST_PROG   = 3'd2,
    ST_VFIRST = 3'd3,
    ST_VER    = 3'd4,
    ST_FAIL   = 3'd5
  } phase_t;

  localparam int STS_READY  = 7;
  localparam int STS_TOGGLE = 6;
  localparam int STS_ERR    = 5;
  localparam int STS_SUPPLY = 4;
endpackage

// File: rtl/mwp_addr_dec.sv
module mwp_addr_dec #(
  parameter int ADDR_W = 22,
  parameter int HI_LSB = 17,
  localparam int HI_W = ADDR_W - HI_LSB
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [HI_W-1:0]   tag,
  output logic              is_cont
);
  // Continue when the upper field matches the phase tag; anything else closes.
  assign is_cont = (addr[ADDR_W-1:HI_LSB] == tag);
endmodule

// File: rtl/mwp_ptr.sv
module mwp_ptr #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  // Next index to use; natural wrap at 2**IDX_W.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_idx + 1'b1;
    else if (step) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/mwp_array.sv
module mwp_array #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  cidx,
  output logic [DATA_W-1:0] cdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we) begin
      mem[widx] <= mem[widx] & wdata;  // programming clears bits only
    end
  end

  assign cdata = mem[cidx];
  assign rdata = mem[ridx];
endmodule

// File: rtl/mwp_status.sv
module mwp_status #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic              in_op,
  input  logic              ready,
  input  logic              err,
  input  logic              supply,
  output logic              tog,
  output logic [DATA_W-1:0] sts
);
  import mwp_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tog <= 1'b0;
    else if (rd_fire && in_op)  tog <= ~tog;
  end

  always_comb begin
    sts             = '0;
    sts[STS_READY]  = ready;
    sts[STS_TOGGLE] = tog;
    sts[STS_ERR]    = err;
    sts[STS_SUPPLY] = supply;
  end
endmodule

// File: rtl/mwp_seq.sv
module mwp_seq #(
  parameter int ADDR_W   = 22,
  parameter int HI_LSB   = 17,
  parameter int DATA_W   = 16,
  parameter int IDX_W    = 6,
  parameter int PROG_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_reset,
  input  logic              supply_fail,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  import mwp_pkg::*;

  localparam int HI_W = ADDR_W - HI_LSB;
  localparam int CW   = $clog2(PROG_CYC + 1);

  phase_t            state, state_nx;
  logic [HI_W-1:0]   tag;
  logic [IDX_W-1:0]  ptr, widx;
  logic [CW-1:0]     gap;
  logic              accept, first_ph, is_cont, mismatch;
  logic              arr_we, ver_step, supply_q, tog;
  logic [DATA_W-1:0] cdata, rdata, sts;

  assign first_ph = (state == ST_PFIRST) || (state == ST_VFIRST);
  assign wr_ready = (state inside {ST_PFIRST, ST_PROG, ST_VFIRST, ST_VER}) && (gap == '0);
  assign accept   = wr_valid && wr_ready;
  assign widx     = first_ph ? wr_addr[IDX_W-1:0] : ptr;
  assign mismatch = (cdata != wr_data);
  assign arr_we   = accept && ((state == ST_PFIRST) || (state == ST_PROG && is_cont));
  assign ver_step = accept && ((state == ST_VFIRST) || (state == ST_VER && is_cont));

  mwp_addr_dec #(.ADDR_W(ADDR_W), .HI_LSB(HI_LSB)) u_dec (
    .addr(wr_addr), .tag(tag), .is_cont(is_cont)
  );

  mwp_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(accept && first_ph), .load_idx(wr_addr[IDX_W-1:0]),
    .step(accept && !first_ph && is_cont), .ptr(ptr)
  );

  mwp_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .we(arr_we), .widx(widx), .wdata(wr_data),
    .cidx(widx), .cdata(cdata),
    .ridx(rd_addr), .rdata(rdata)
  );

  mwp_status #(.DATA_W(DATA_W)) u_sts (
    .clk(clk), .rst_n(rst_n),
    .rd_fire(rd_en), .in_op(state != ST_READ),
    .ready(gap == '0), .err(state == ST_FAIL), .supply(supply_q),
    .tog(tog), .sts(sts)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_READ:   if (cmd_start) state_nx = ST_PFIRST;
      ST_PFIRST: if (accept) state_nx = ST_PROG;
      ST_PROG:   if (accept && !is_cont) state_nx = ST_VFIRST;
      ST_VFIRST: if (accept) state_nx = mismatch ? ST_FAIL : ST_VER;
      ST_VER: begin
        if (accept) begin
          if (!is_cont)     state_nx = ST_READ;
          else if (mismatch) state_nx = ST_FAIL;
        end
      end
      ST_FAIL:   if (cmd_reset) state_nx = ST_READ;
      default:   state_nx = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_READ;
      tag      <= '0;
      gap      <= '0;
      supply_q <= 1'b0;
      rd_data  <= '0;
    end else begin
      state <= state_nx;
      if (accept && first_ph) tag <= wr_addr[ADDR_W-1:HI_LSB];
      if (accept)             gap <= CW'(PROG_CYC);
      else if (gap != '0)     gap <= gap - 1'b1;
      if (ver_step && mismatch)                 supply_q <= supply_fail;
      else if (state == ST_FAIL && cmd_reset)   supply_q <= 1'b0;
      if (rd_en) rd_data <= (state == ST_READ) ? rdata : sts;
    end
  end
endmodule

// File: rtl/mwp_seq_chk.sv
module mwp_seq_chk (
  input logic            clk,
  input logic            rst_n,
  input mwp_pkg::phase_t state,
  input logic            accept,
  input logic            is_cont,
  input logic            cmd_reset,
  input logic            wr_ready,
  input logic            rd_en,
  input logic            tog
);
  import mwp_pkg::*;

  a_r10_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !wr_ready);

  a_r8_hold_in_progress: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_READ && state != ST_FAIL && !accept) |=> $stable(state));

  a_r6_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAIL && !cmd_reset) |=> (state == ST_FAIL));

  a_r9_reset_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAIL && cmd_reset) |=> (state == ST_READ));

  a_r3_close_to_verify: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG && accept && !is_cont) |=> (state == ST_VFIRST));

  a_r11_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && state != ST_READ) |=> (tog != $past(tog)));
endmodule

bind mwp_seq mwp_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .accept(accept),
  .is_cont(is_cont), .cmd_reset(cmd_reset), .wr_ready(wr_ready),
  .rd_en(rd_en), .tog(tog)
);

// File: tb/mwp_seq_tb.sv
module mwp_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0, cmd_reset = 1'b0, supply_fail = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [21:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int nvec = 0, nbad = 0;
  logic [15:0] r, r2;

  localparam logic [15:0] PAT [8] = '{16'hA5C3, 16'h7E81, 16'h1234, 16'hFEDC,
                                      16'h0F0F, 16'hC0DE, 16'h5A5A, 16'h8001};

  always #5 clk = ~clk;

  mwp_seq u_dut (.*);

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [21:0] a, input logic [15:0] d);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [5:0] a, output logic [15:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse_start();
    cmd_start = 1'b1; @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic pulse_reset();
    cmd_reset = 1'b1; @(negedge clk); cmd_reset = 1'b0;
  endtask

  function automatic logic [21:0] ad(input logic [4:0] hi, input logic [16:0] lo);
    return {hi, lo};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk({15'd0, wr_ready}, 16'd0, "R1 wr_ready idle");
    do_read(6'd5, r);  chk(r, 16'hFFFF, "R1 erased word");

    // Program burst starting at 60, wrapping (R2, R12); tag 3
    pulse_start();
    for (int i = 0; i < 8; i++) begin
      if (i == 0) do_write(ad(5'd3, 17'd60), PAT[i]);
      else        do_write(ad(5'd3, 17'h1ABC0 + 17'(i)), PAT[i]);
      if (i == 0) begin
        chk({15'd0, wr_ready}, 16'd0, "R10 wr_ready low after write");
        do_read(6'd0, r);
        chk({15'd0, r[7]}, 16'd0, "R10 status ready bit low in gap");
      end
      if (i == 3) begin
        pulse_reset();  // R8: must be ignored
        pulse_start();
        do_read(6'd60, r);
        chk(r & 16'hFF2F, 16'h0000, "R8 read returns status in program");
        do_read(6'd60, r2);
        chk({15'd0, r[6] ^ r2[6]}, 16'd1, "R11 toggle between status reads");
      end
    end
    do_write(ad(5'd2, 17'd61), 16'h0000);  // R3: close, differs only in bit 17

    // Verify pass, tag 7
    for (int i = 0; i < 8; i++) begin
      if (i == 0) do_write(ad(5'd7, 17'd60), PAT[i]);
      else        do_write(ad(5'd7, 17'h00FF0 + 17'(i)), PAT[i]);
    end
    do_write(ad(5'd23, 17'd0), 16'h0000);
    repeat (4) @(negedge clk);

    // Table walk: readback after verify (R5, R12, R2)
    for (int i = 0; i < 8; i++) begin
      do_read(6'(60 + i), r);
      chk(r, PAT[i], "R5/R12 readback of burst word");
    end
    do_read(6'd4, r);  chk(r, 16'hFFFF, "R3 closing write stored nothing");
    do_read(6'd59, r); chk(r, 16'hFFFF, "R2 word before start untouched");
    chk({15'd0, wr_ready}, 16'd0, "R5 read mode no write ready");

    // R4: AND semantics over two commands
    pulse_start();
    do_write(ad(5'd1, 17'd10), 16'hF0F0);
    do_write(ad(5'd0, 17'd0), 16'h0);
    do_write(ad(5'd1, 17'd10), 16'hF0F0);
    do_write(ad(5'd0, 17'd0), 16'h0);
    pulse_start();
    do_write(ad(5'd1, 17'd10), 16'h0FFF);
    do_write(ad(5'd0, 17'd0), 16'h0);
    do_write(ad(5'd1, 17'd10), 16'h00F0);
    do_write(ad(5'd0, 17'd0), 16'h0);
    repeat (4) @(negedge clk);
    do_read(6'd10, r); chk(r, 16'h00F0, "R4 bits only cleared");

    // R6/R7: mismatch on first verify word with supply fault
    pulse_start();
    do_write(ad(5'd4, 17'd20), 16'h1234);
    do_write(ad(5'd5, 17'd0), 16'h0);
    supply_fail = 1'b1;
    do_write(ad(5'd4, 17'd20), 16'h1235);
    supply_fail = 1'b0;
    repeat (4) @(negedge clk);
    chk({15'd0, wr_ready}, 16'd0, "R6 no write ready in error");
    do_read(6'd20, r);
    chk(r & 16'hFFBF, 16'h00B0, "R6/R7 error status with supply bit");
    pulse_start();  // ignored in error (R8)
    do_read(6'd20, r2);
    chk({15'd0, r[6] ^ r2[6]}, 16'd1, "R6 toggle continues in error");
    chk(r2 & 16'hFFBF, 16'h00B0, "R8 start ignored in error");
    pulse_reset();
    do_read(6'd20, r); chk(r, 16'h1234, "R9 reset returns read mode");

    // R7: mismatch on a later word, no supply fault
    pulse_start();
    do_write(ad(5'd6, 17'd30), 16'hAAAA);
    do_write(ad(5'd6, 17'd5), 16'h5555);
    do_write(ad(5'd9, 17'd0), 16'h0);
    do_write(ad(5'd6, 17'd30), 16'hAAAA);
    do_write(ad(5'd6, 17'd7), 16'h5554);
    repeat (4) @(negedge clk);
    do_read(6'd0, r);
    chk(r & 16'hFFBF, 16'h00A0, "R7 error without supply bit");
    pulse_reset();
    do_read(6'd31, r); chk(r, 16'h5555, "R9 data kept after reset");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule